// File: doc/BRIEF.md
# Word-Organised Serial EEPROM Slave

This block is a synthesizable behavioural model of a serial EEPROM that stores 16-bit words and answers on a four-wire serial bus: an active-high select, a serial clock, a serial data input and a serial data output with its own output enable. Each transaction is one select window. The host sends an 8-bit opcode, then an 8-bit address field, and then either sends 16 data bits or clocks 16 data bits back. The system clock oversamples the serial pins, so the serial clock must be several times slower than the system clock.

Five opcodes are decoded: read, single-word write, set write enable, clear write enable, and a test-mode write that fills the whole array with one word. Programming is refused until write enable has been set. A write is self-timed. The target word is erased when the write is accepted and programmed when a fixed number of system clocks has elapsed. A ready output is low for the whole of that interval. A synchronous hardware reset input aborts any transfer or write in flight and clears the write-enable latch. It does not clear the array.

The array has 256 words by default. The depth is a parameter, and only the low address bits that the depth needs are decoded. No interface of this block carries a data stream with flow control: the serial pins follow the bus clock, and ready is a plain status level.

Top module: `spi_word_eeprom`

## Requirements
- R1: After system reset, ready is 1, ser_doe is 0 and the write-enable latch is clear, so a write frame sent before any enable command leaves ready high.
- R2: Opcode 0xA8 followed by an address byte returns the stored word on ser_dout, bit 15 first, one bit per falling edge of ser_clk starting with the falling edge that ends the address byte. ser_doe is 1 while those 16 bits are presented and 0 once the frame ends.
- R3: Opcode 0xA4, an address byte and 16 data bits (bit 15 first) store that word at the addressed location when the write-enable latch is set.
- R4: Opcode 0xA3 sets the write-enable latch and opcode 0xA0 clears it. While the latch is clear, a write frame starts no write cycle and memory keeps its content.
- R5: Opcode 0xA1 with any address byte and 16 data bits stores the word in every location when the write-enable latch is set.
- R6: An accepted write or fill holds ready at 0 for exactly WR_CYCLES system clock cycles, after which the new data can be read.
- R7: A frame that begins while ready is 0 is ignored in full: memory is not changed by it and ser_doe stays 0.
- R8: Dropping ser_sel before a write frame is complete discards the frame: no write cycle starts and memory is unchanged.
- R9: While hw_rst is 1 on a clock edge, ready is 1 and ser_doe is 0 after that edge. An aborted write leaves its target word erased (0xFFFF), and the write-enable latch is cleared.
- R10: An opcode other than the five above produces no output (ser_doe stays 0) and changes no memory.
- R11: The write-enable latch stays set across any number of completed writes until it is cleared by opcode 0xA0, hw_rst or system reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low system reset |
| hw_rst | input | 1 | Synchronous active-high abort and reset of the serial interface |
| ser_sel | input | 1 | Active-high select; a frame is one high window |
| ser_clk | input | 1 | Serial bit clock; input sampled on rise, output shifted on fall |
| ser_din | input | 1 | Serial data input, opcode/address/data, MSB first |
| ser_dout | output | 1 | Serial read data, MSB first |
| ser_doe | output | 1 | High while ser_dout carries read data; otherwise the pad floats |
| ready | output | 1 | 1 when idle, 0 during a self-timed write |

## Verification
A wrong latch or phase state shows at the ports within one frame. A mis-set write-enable latch makes ready fall, or fail to fall, a few system clocks after the last data bit. A phase counter that is off by one shifts every bit of the next read word or leaves ser_doe high after the frame. Errors in the write timer or in the erase and program strobes stay hidden until a read-back after ready rises. For that reason every write is followed by a read, and the number of busy cycles is counted exactly.

// File: rtl/eep_pkg.sv
package eep_pkg;
  localparam int WORD_W = 16;
  localparam int FIELD_W = 8;
  localparam int FRAME_HDR = 2 * FIELD_W;

  localparam logic [FIELD_W-1:0] OPC_READ = 8'hA8;
  localparam logic [FIELD_W-1:0] OPC_WRITE = 8'hA4;
  localparam logic [FIELD_W-1:0] OPC_WREN = 8'hA3;
  localparam logic [FIELD_W-1:0] OPC_WRDIS = 8'hA0;
  localparam logic [FIELD_W-1:0] OPC_FILL = 8'hA1;

  localparam logic [WORD_W-1:0] ERASED_WORD = '1;

  typedef enum logic [1:0] {
    PH_HDR,
    PH_DATA,
    PH_READ,
    PH_DONE
  } phase_t;

  typedef struct packed {
    logic all;
    logic [FIELD_W-1:0] addr;
    logic [WORD_W-1:0] data;
  } wr_req_t;
endpackage

// File: rtl/eep_sync.sv
module eep_sync #(
  parameter int WIDTH = 3,
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else chain <= {chain[STAGES-2:0], async_i[b]};
    end
    assign sync_o[b] = chain[STAGES-1];
  end
endmodule

// File: rtl/eep_ctrl.sv
module eep_ctrl import eep_pkg::*; #(
  parameter int AW = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hw_rst,
  input  logic sel_s,
  input  logic din_s,
  input  logic sk_rise,
  input  logic sk_fall,
  input  logic busy,
  input  logic [WORD_W-1:0] rd_data,
  output logic [AW-1:0] rd_addr,
  output logic wr_start,
  output wr_req_t wr_req,
  output logic dout,
  output logic doe,
  output logic wel
);
  localparam int CW = $clog2(FRAME_HDR);
  localparam int OW = $clog2(WORD_W + 1);

  phase_t phase;
  logic [CW-1:0] bit_cnt;
  logic [OW-1:0] out_cnt;
  logic [FRAME_HDR-1:0] in_sh;
  logic [WORD_W-1:0] out_sh;
  logic [FIELD_W-1:0] op_q, addr_q;
  logic [FRAME_HDR-1:0] next_sh;
  logic last_bit;

  assign next_sh = {in_sh[FRAME_HDR-2:0], din_s};
  assign last_bit = (bit_cnt == CW'(FRAME_HDR - 1));
  assign rd_addr = addr_q[AW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_HDR;
      bit_cnt <= '0;
      out_cnt <= '0;
      in_sh <= '0;
      out_sh <= '0;
      op_q <= '0;
      addr_q <= '0;
      wr_start <= 1'b0;
      wr_req <= '0;
      dout <= 1'b0;
      doe <= 1'b0;
      wel <= 1'b0;
    end else if (hw_rst) begin
      phase <= PH_HDR;
      bit_cnt <= '0;
      out_cnt <= '0;
      wr_start <= 1'b0;
      doe <= 1'b0;
      wel <= 1'b0;
    end else begin
      wr_start <= 1'b0;
      if (!sel_s) begin
        phase <= PH_HDR;
        bit_cnt <= '0;
        out_cnt <= '0;
        doe <= 1'b0;
      end else begin
        unique case (phase)
          PH_HDR: begin
            if (busy) begin
              phase <= PH_DONE;
            end else if (sk_rise) begin
              in_sh <= next_sh;
              bit_cnt <= bit_cnt + 1'b1;
              if (last_bit) begin
                op_q <= next_sh[FRAME_HDR-1:FIELD_W];
                addr_q <= next_sh[FIELD_W-1:0];
                unique case (next_sh[FRAME_HDR-1:FIELD_W])
                  OPC_READ: begin
                    phase <= PH_READ;
                    out_cnt <= '0;
                  end
                  OPC_WRITE, OPC_FILL: phase <= wel ? PH_DATA : PH_DONE;
                  OPC_WREN: begin
                    wel <= 1'b1;
                    phase <= PH_DONE;
                  end
                  OPC_WRDIS: begin
                    wel <= 1'b0;
                    phase <= PH_DONE;
                  end
                  default: phase <= PH_DONE;
                endcase
              end
            end
          end
          PH_DATA: begin
            if (sk_rise) begin
              in_sh <= next_sh;
              bit_cnt <= bit_cnt + 1'b1;
              if (last_bit) begin
                wr_start <= 1'b1;
                wr_req.all <= (op_q == OPC_FILL);
                wr_req.addr <= addr_q;
                wr_req.data <= next_sh[WORD_W-1:0];
                phase <= PH_DONE;
              end
            end
          end
          PH_READ: begin
            if (sk_fall) begin
              out_cnt <= out_cnt + 1'b1;
              if (out_cnt == '0) begin
                dout <= rd_data[WORD_W-1];
                out_sh <= {rd_data[WORD_W-2:0], 1'b0};
                doe <= 1'b1;
              end else if (out_cnt < OW'(WORD_W)) begin
                dout <= out_sh[WORD_W-1];
                out_sh <= {out_sh[WORD_W-2:0], 1'b0};
              end else begin
                doe <= 1'b0;
                phase <= PH_DONE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/eep_store.sv
module eep_store import eep_pkg::*; #(
  parameter int DEPTH = 256,
  parameter int WR_CYCLES = 2000,
  parameter int AW = $clog2(DEPTH)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hw_rst,
  input  logic wr_start,
  input  wr_req_t wr_req,
  input  logic [AW-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_data,
  output logic busy
);
  localparam int TW = $clog2(WR_CYCLES + 1);

  logic [WORD_W-1:0] mem [DEPTH];
  logic [TW-1:0] cnt;
  logic pend_all;
  logic [AW-1:0] pend_addr;
  logic [WORD_W-1:0] pend_data;
  logic finish;
  logic [DEPTH-1:0] erase_hit, prog_hit;

  assign finish = busy && (cnt == '0) && !hw_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt <= '0;
      pend_all <= 1'b0;
      pend_addr <= '0;
      pend_data <= '0;
    end else if (hw_rst) begin
      busy <= 1'b0;
      cnt <= '0;
    end else if (wr_start) begin
      busy <= 1'b1;
      cnt <= TW'(WR_CYCLES - 1);
      pend_all <= wr_req.all;
      pend_addr <= wr_req.addr[AW-1:0];
      pend_data <= wr_req.data;
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else cnt <= cnt - 1'b1;
    end
  end

  for (genvar w = 0; w < DEPTH; w++) begin : g_word
    assign erase_hit[w] = wr_start && !hw_rst &&
                          (wr_req.all || (wr_req.addr[AW-1:0] == AW'(w)));
    assign prog_hit[w] = finish && (pend_all || (pend_addr == AW'(w)));
  end

  always_ff @(posedge clk) begin
    for (int w = 0; w < DEPTH; w++) begin
      if (erase_hit[w]) mem[w] <= ERASED_WORD;
      else if (prog_hit[w]) mem[w] <= pend_data;
    end
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/spi_word_eeprom.sv
module spi_word_eeprom import eep_pkg::*; #(
  parameter int DEPTH = 256,
  parameter int WR_CYCLES = 2000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hw_rst,
  input  logic ser_sel,
  input  logic ser_clk,
  input  logic ser_din,
  output logic ser_dout,
  output logic ser_doe,
  output logic ready
);
  localparam int AW = $clog2(DEPTH);

  logic [2:0] pins_s;
  logic sk_s, sel_s, din_s, sk_prev;
  logic sk_rise, sk_fall;
  logic busy, wr_start, wel;
  wr_req_t wr_req;
  logic [AW-1:0] rd_addr;
  logic [WORD_W-1:0] rd_data;

  eep_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk),
    .rst_n(rst_n),
    .async_i({ser_clk, ser_sel, ser_din}),
    .sync_o(pins_s)
  );

  assign {sk_s, sel_s, din_s} = pins_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sk_prev <= 1'b0;
    else sk_prev <= sk_s;
  end

  assign sk_rise = sk_s && !sk_prev;
  assign sk_fall = !sk_s && sk_prev;

  eep_ctrl #(.AW(AW)) u_ctrl (
    .clk(clk),
    .rst_n(rst_n),
    .hw_rst(hw_rst),
    .sel_s(sel_s),
    .din_s(din_s),
    .sk_rise(sk_rise),
    .sk_fall(sk_fall),
    .busy(busy),
    .rd_data(rd_data),
    .rd_addr(rd_addr),
    .wr_start(wr_start),
    .wr_req(wr_req),
    .dout(ser_dout),
    .doe(ser_doe),
    .wel(wel)
  );

  eep_store #(.DEPTH(DEPTH), .WR_CYCLES(WR_CYCLES), .AW(AW)) u_store (
    .clk(clk),
    .rst_n(rst_n),
    .hw_rst(hw_rst),
    .wr_start(wr_start),
    .wr_req(wr_req),
    .rd_addr(rd_addr),
    .rd_data(rd_data),
    .busy(busy)
  );

  assign ready = !busy;
endmodule

// File: rtl/eep_checker.sv
module eep_checker (
  input logic clk,
  input logic rst_n,
  input logic hw_rst,
  input logic ready,
  input logic ser_doe,
  input logic ser_dout,
  input logic sk_fall,
  input logic wr_start,
  input logic wel
);
  AST_WRITE_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
    wr_start |-> wel); // R4

  AST_START_FROM_READY: assert property (@(posedge clk) disable iff (!rst_n)
    wr_start |-> ready); // R7

  AST_START_GOES_BUSY: assert property (@(posedge clk) disable iff (!rst_n || hw_rst)
    wr_start |=> !ready); // R6

  AST_HWRST_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    hw_rst |=> (ready && !ser_doe)); // R9

  AST_QUIET_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> !ser_doe); // R7

  AST_DOUT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_doe && $past(ser_doe) && !$past(sk_fall)) |-> $stable(ser_dout)); // R2
endmodule

bind spi_word_eeprom eep_checker u_chk (
  .clk(clk),
  .rst_n(rst_n),
  .hw_rst(hw_rst),
  .ready(ready),
  .ser_doe(ser_doe),
  .ser_dout(ser_dout),
  .sk_fall(sk_fall),
  .wr_start(wr_start),
  .wel(wel)
);

// File: tb/spi_word_eeprom_test.sv
`timescale 1ns/1ps
module spi_word_eeprom_test;
  localparam int WR = 1000;
  localparam int HALF = 8;
  localparam int NVEC = 6;
  localparam logic [23:0] VEC [NVEC] = '{
    {8'h00, 16'h1234}, {8'hFF, 16'hFFFF}, {8'h01, 16'h0000},
    {8'h80, 16'hA55A}, {8'h7F, 16'h8001}, {8'h42, 16'h0F0F}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hw_rst = 1'b0;
  logic sel = 1'b0;
  logic sck = 1'b0;
  logic din = 1'b0;
  logic dout, doe, ready;
  int n_chk = 0;
  int n_err = 0;
  logic clr_low = 1'b0;
  int low_cnt = 0;

  always #2 clk = ~clk;

  spi_word_eeprom #(.WR_CYCLES(WR)) uut (
    .clk(clk), .rst_n(rst_n), .hw_rst(hw_rst),
    .ser_sel(sel), .ser_clk(sck), .ser_din(din),
    .ser_dout(dout), .ser_doe(doe), .ready(ready)
  );

  always @(posedge clk) begin
    if (clr_low) low_cnt <= 0;
    else if (!ready) low_cnt <= low_cnt + 1;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic shift_in(input logic [15:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      din = v[i];
      tick(HALF);
      sck = 1'b1;
      tick(HALF);
      sck = 1'b0;
    end
  endtask

  task automatic open_frame();
    sel = 1'b1;
    tick(HALF);
  endtask

  task automatic close_frame();
    tick(HALF);
    sel = 1'b0;
    tick(3 * HALF);
  endtask

  task automatic cmd(input logic [7:0] op, input logic [7:0] a);
    open_frame();
    shift_in({op, a}, 16);
    close_frame();
  endtask

  task automatic wr(input logic [7:0] op, input logic [7:0] a, input logic [15:0] d);
    clr_low = 1'b1;
    tick(1);
    clr_low = 1'b0;
    open_frame();
    shift_in({op, a}, 16);
    shift_in(d, 16);
    close_frame();
  endtask

  task automatic rd(input logic [7:0] op, input logic [7:0] a, output logic [15:0] d, output int oe_n);
    open_frame();
    shift_in({op, a}, 16);
    oe_n = 0;
    for (int i = 15; i >= 0; i--) begin
      tick(HALF);
      if (doe) oe_n++;
      d[i] = dout;
      sck = 1'b1;
      tick(HALF);
      sck = 1'b0;
    end
    close_frame();
  endtask

  task automatic wait_ready();
    int t = 0;
    while (!ready && t < 5000) begin
      tick(1);
      t++;
    end
    tick(2);
  endtask

  task automatic expect_word(input logic [7:0] a, input logic [15:0] exp, input string req);
    logic [15:0] got;
    int oe_n;
    rd(OPC_RD, a, got, oe_n);
    check(got === exp, req, {16'h0, got}, {16'h0, exp});
    check(oe_n == 16, {req, " doe during read"}, oe_n, 16);
    check(doe == 1'b0, {req, " doe after frame"}, doe, 0);
  endtask

  localparam logic [7:0] OPC_RD = 8'hA8;
  localparam logic [7:0] OPC_WR = 8'hA4;
  localparam logic [7:0] OPC_EN = 8'hA3;
  localparam logic [7:0] OPC_DIS = 8'hA0;
  localparam logic [7:0] OPC_ALL = 8'hA1;

  initial begin
    logic [15:0] got;
    int oe_n;
    tick(5);
    rst_n = 1'b1;
    tick(5);
    check(ready == 1'b1, "R1 ready after reset", ready, 1);
    check(doe == 1'b0, "R1 doe after reset", doe, 0);
    wr(OPC_WR, 8'h10, 16'hBEEF);
    tick(20);
    check(low_cnt == 0, "R1 write refused before enable", low_cnt, 0);

    cmd(OPC_EN, 8'h00);
    for (int v = 0; v < NVEC; v++) begin
      wr(OPC_WR, VEC[v][23:16], VEC[v][15:0]);
      wait_ready();
      check(low_cnt == WR, "R6 busy length", low_cnt, WR);
      expect_word(VEC[v][23:16], VEC[v][15:0], "R3 R2 R11 table read-back");
    end

    cmd(OPC_DIS, 8'h00);
    wr(OPC_WR, 8'h00, 16'hDEAD);
    tick(20);
    check(low_cnt == 0, "R4 no busy after disable", low_cnt, 0);
    expect_word(8'h00, 16'h1234, "R4 word kept after disable");

    cmd(OPC_EN, 8'h00);
    clr_low = 1'b1;
    tick(1);
    clr_low = 1'b0;
    open_frame();
    shift_in({OPC_WR, 8'h01}, 16);
    shift_in(16'hC3C3, 8);
    close_frame();
    tick(20);
    check(low_cnt == 0, "R8 aborted frame no busy", low_cnt, 0);
    expect_word(8'h01, 16'h0000, "R8 word kept after abort");

    rd(8'hFF, 8'h42, got, oe_n);
    check(oe_n == 0, "R10 unknown opcode drives nothing", oe_n, 0);
    expect_word(8'h42, 16'h0F0F, "R10 word kept");

    wr(OPC_WR, 8'h80, 16'h1111);
    wr(OPC_WR, 8'h7F, 16'h2222);
    rd(OPC_RD, 8'h42, got, oe_n);
    check(oe_n == 0, "R7 read while busy is ignored", oe_n, 0);
    wait_ready();
    expect_word(8'h80, 16'h1111, "R3 first write landed");
    expect_word(8'h7F, 16'h8001, "R7 write while busy ignored");

    wr(OPC_WR, 8'h42, 16'h3333);
    tick(50);
    check(ready == 1'b0, "R6 busy during write", ready, 0);
    hw_rst = 1'b1;
    tick(1);
    check(ready == 1'b1, "R9 ready after hw reset", ready, 1);
    check(doe == 1'b0, "R9 doe after hw reset", doe, 0);
    hw_rst = 1'b0;
    tick(4);
    expect_word(8'h42, 16'hFFFF, "R9 aborted word erased");
    wr(OPC_WR, 8'h42, 16'h4444);
    tick(20);
    check(low_cnt == 0, "R9 latch cleared by hw reset", low_cnt, 0);
    expect_word(8'h42, 16'hFFFF, "R9 word unchanged without enable");

    cmd(OPC_EN, 8'h00);
    wr(OPC_ALL, 8'h13, 16'h5AC3);
    wait_ready();
    check(low_cnt == WR, "R6 R5 fill busy length", low_cnt, WR);
    expect_word(8'h00, 16'h5AC3, "R5 fill word 0x00");
    expect_word(8'hFF, 16'h5AC3, "R5 fill word 0xFF");
    expect_word(8'h42, 16'h5AC3, "R5 fill word 0x42");

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(4 * 190000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule